// File: doc/BRIEF.md
# Serial Register Access Controller

This block is the device-side serial port of a small converter register set. A host clocks bits in on `sdi` and out on `sdo` under its own serial clock. Every exchange opens with a one-byte command. The command chooses one of four registers and a direction, and the following transfer of 8 or 16 bits goes to that register. On the core side the block presents the contents of the three writable 8-bit registers, a test-mode flag, and a one-cycle strobe for each register access. It also captures the 16-bit conversion result supplied by the core.

Two rules make the port robust. First, a write aimed at the read-only result register is not refused: all 16 bits are clocked in and thrown away, and only then does the port wait for a new command. Second, a host that has lost bit alignment can hold `sdi` high for 32 consecutive serial clocks. This returns the port to the command-wait state with its bit counter cleared, whatever it was doing.

The controller has five named states:
- `ST_COMM`: shifting in a command byte.
- `ST_WR8`: receiving an 8-bit write.
- `ST_RD8`: sending an 8-bit register.
- `ST_RD16`: sending the captured result.
- `ST_DISC16`: swallowing a 16-bit write to the result register.

The transitions are:
- `ST_COMM` to one of the other four states when a valid command completes.
- `ST_COMM` to `ST_COMM` when a byte is rejected.
- Each data state back to `ST_COMM` on its last bit.
- Any state to `ST_COMM` on the ones-run resynchronisation.

Top module: `serreg_ctrl`

## Requirements
- R1: A synchronous reset, sampled on the rising `sclk` edge, clears all three 8-bit registers, the test flag and all strobes, and leaves the port in `ST_COMM` with `sdo` and `sdo_oe` at 0.
- R2: Command bytes arrive MSB first. A command byte whose bit 7 is 1 is rejected and causes no access. The next 8 bits are taken as a fresh command byte.
- R3: A command with bit 7 = 0 carries the target code in bits 5:4 and the direction in bit 3 (1 = read, 0 = write). Code 00 selects the control register, 01 the setup register, 10 the test register and 11 the result register. Bits 6 and 2:0 have no effect.
- R4: After a write command to code 00, 01 or 10, the next 8 bits, MSB first, replace that register on the 8th rising edge. The matching strobe is high for exactly the following cycle.
- R5: After a read command to code 00, 01 or 10, the register is sent MSB first on `sdo` over the next 8 cycles. Each bit changes on a falling edge, the first on the falling edge right after the command's last rising edge. `sdo_oe` is high for those 8 bits only.
- R6: A read command to code 11 captures `result_in` as sampled on the command's last rising edge, pulses `result_stb` for one cycle, and sends the 16 captured bits MSB first. Later changes of `result_in` do not alter the bits sent.
- R7: A write command to code 11 consumes the next 16 bits and changes no register and no strobe. The port then takes the following 8 bits as a command byte.
- R8: When `sdi` has been 1 on 32 consecutive rising edges, the port is in `ST_COMM` with a cleared bit count after the 32nd edge, even if that edge also ends a byte. The run counter then restarts from zero.
- R9: `test_mode` is high exactly while the test register is nonzero. Writing zeros to it (for example after an R8 resynchronisation) or a hardware reset clears it.
- R10: Outside read phases `sdo` and `sdo_oe` are 0, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; inputs sampled on rising edge, `sdo` updated on falling edge |
| rst | input | 1 | Synchronous reset, active high |
| sdi | input | 1 | Serial data in, MSB first |
| result_in | input | 16 | Latest conversion result from the core |
| sdo | output | 1 | Serial data out, 0 when not reading |
| sdo_oe | output | 1 | High while a read phase drives `sdo` |
| ctrl_q | output | 8 | Control register contents |
| setup_q | output | 8 | Setup register contents |
| test_q | output | 8 | Test register contents |
| test_mode | output | 1 | High while the test register is nonzero |
| ctrl_stb | output | 1 | One-cycle pulse after a control register write |
| setup_stb | output | 1 | One-cycle pulse after a setup register write |
| test_stb | output | 1 | One-cycle pulse after a test register write |
| result_stb | output | 1 | One-cycle pulse when the result is captured for a read |

## Verification
Two functions can coincide on a single rising edge.

The first is the 32nd one of a resynchronisation run landing on the last bit of a command byte, so the byte boundary and the run reset act together. The bench provokes this by sending exactly 32 ones straight after reset. It then expects the very next byte to decode as a command, which it does only if the bit count was cleared rather than carried over.

The second is the core changing `result_in` in the same cycle whose closing edge completes a result-read command. The bench changes the value just before that edge and expects the new value on `sdo`, not the older one.

Both cases are judged by a behavioural bit-level model that is compared with every output on every edge.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

    typedef enum logic [2:0] {
        ST_COMM,
        ST_WR8,
        ST_RD8,
        ST_RD16,
        ST_DISC16
    } serreg_state_e;

    localparam logic [1:0] SEL_CTRL  = 2'b00;
    localparam logic [1:0] SEL_SETUP = 2'b01;
    localparam logic [1:0] SEL_TEST  = 2'b10;
    localparam logic [1:0] SEL_RES   = 2'b11;

    // command byte field positions
    localparam int CMD_INVALID_BIT = 7;
    localparam int CMD_SEL_HI      = 5;
    localparam int CMD_SEL_LO      = 4;
    localparam int CMD_READ_BIT    = 3;

endpackage

// File: rtl/serreg_resync.sv
module serreg_resync #(
    parameter int RUN_LEN = 32
) (
    input  logic sclk,
    input  logic rst,
    input  logic sdi,
    output logic hit
);
    localparam int CNT_W = $clog2(RUN_LEN);

    logic [CNT_W-1:0] run_cnt;

    always_comb begin
        hit = sdi && (run_cnt == CNT_W'(RUN_LEN - 1));
    end

    always_ff @(posedge sclk) begin
        if (rst || hit || !sdi) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // a zero on the line always breaks the run
    p_run_break_r8: assert property (@(posedge sclk) disable iff (rst)
        (!sdi) |=> (run_cnt == '0));

endmodule

// File: rtl/serreg_fsm.sv
module serreg_fsm
    import serreg_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int RES_W = 16
) (
    input  logic                 sclk,
    input  logic                 rst,
    input  logic                 sdi,
    input  logic                 resync_hit,
    output serreg_state_e        state,
    output logic [REG_W-1:0]     rx_word,
    output logic [1:0]           tgt_sel,
    output logic                 wr_commit,
    output logic                 rd_load,
    output logic                 tx_active
);
    localparam int CNT_W = $clog2(RES_W);

    serreg_state_e      state_n;
    logic [CNT_W-1:0]   bit_cnt;
    logic [CNT_W-1:0]   cnt_n;
    logic [CNT_W-1:0]   last_idx;
    logic [REG_W-2:0]   rx_shift;
    logic [1:0]         sel_q;
    logic               at_last;
    logic               cmd_ok;

    // phase length and incoming word
    always_comb begin
        rx_word = {rx_shift, sdi};
        unique case (state)
            ST_RD16, ST_DISC16: last_idx = CNT_W'(RES_W - 1);
            default:            last_idx = CNT_W'(REG_W - 1);
        endcase
        at_last = (bit_cnt == last_idx);
        cmd_ok  = !rx_word[CMD_INVALID_BIT];
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = at_last ? '0 : bit_cnt + 1'b1;
        unique case (state)
            ST_COMM: begin
                if (at_last && cmd_ok) begin
                    if (rx_word[CMD_READ_BIT]) begin
                        state_n = (rx_word[CMD_SEL_HI:CMD_SEL_LO] == SEL_RES) ? ST_RD16 : ST_RD8;
                    end else begin
                        state_n = (rx_word[CMD_SEL_HI:CMD_SEL_LO] == SEL_RES) ? ST_DISC16 : ST_WR8;
                    end
                end
            end
            ST_WR8, ST_RD8, ST_RD16, ST_DISC16: begin
                if (at_last) begin
                    state_n = ST_COMM;
                end
            end
            default: state_n = ST_COMM;
        endcase
    end

    // state register
    always_ff @(posedge sclk) begin
        if (rst) begin
            state    <= ST_COMM;
            bit_cnt  <= '0;
            rx_shift <= '0;
            sel_q    <= SEL_CTRL;
        end else if (resync_hit) begin
            state    <= ST_COMM;
            bit_cnt  <= '0;
            rx_shift <= '0;
        end else begin
            state    <= state_n;
            bit_cnt  <= cnt_n;
            rx_shift <= rx_word[REG_W-2:0];
            if (state == ST_COMM && at_last) begin
                sel_q <= rx_word[CMD_SEL_HI:CMD_SEL_LO];
            end
        end
    end

    // outputs
    always_comb begin
        wr_commit = (state == ST_WR8) && at_last && !resync_hit;
        rd_load   = (state == ST_COMM) && at_last && cmd_ok
                    && rx_word[CMD_READ_BIT] && !resync_hit;
        tx_active = (state == ST_RD8) || (state == ST_RD16);
        tgt_sel   = (state == ST_COMM) ? rx_word[CMD_SEL_HI:CMD_SEL_LO] : sel_q;
    end

    // a discarded write ends after its 16th bit
    p_discard_end_r7: assert property (@(posedge sclk) disable iff (rst)
        (state == ST_DISC16 && at_last) |=> (state == ST_COMM));

endmodule

// File: rtl/serreg_regs.sv
module serreg_regs
    import serreg_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              wr_commit,
    input  logic              rd_load,
    input  logic [1:0]        tgt_sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [REG_W-1:0]  setup_q,
    output logic [REG_W-1:0]  test_q,
    output logic              test_mode,
    output logic              ctrl_stb,
    output logic              setup_stb,
    output logic              test_stb,
    output logic              result_stb
);
    logic wr_test;

    always_comb begin
        wr_test   = wr_commit && (tgt_sel == SEL_TEST);
        test_mode = |test_q;
    end

    always_ff @(posedge sclk) begin
        if (rst) begin
            ctrl_q     <= '0;
            setup_q    <= '0;
            test_q     <= '0;
            ctrl_stb   <= 1'b0;
            setup_stb  <= 1'b0;
            test_stb   <= 1'b0;
            result_stb <= 1'b0;
        end else begin
            ctrl_stb   <= wr_commit && (tgt_sel == SEL_CTRL);
            setup_stb  <= wr_commit && (tgt_sel == SEL_SETUP);
            test_stb   <= wr_test;
            result_stb <= rd_load && (tgt_sel == SEL_RES);
            if (wr_commit) begin
                unique case (tgt_sel)
                    SEL_CTRL:  ctrl_q  <= wdata;
                    SEL_SETUP: setup_q <= wdata;
                    SEL_TEST:  test_q  <= wdata;
                    default:   ;
                endcase
            end
        end
    end

    p_one_strobe_r10: assert property (@(posedge sclk) disable iff (rst)
        $onehot0({ctrl_stb, setup_stb, test_stb, result_stb}));

    p_test_hold_r9: assert property (@(posedge sclk) disable iff (rst)
        (!wr_test) |=> $stable(test_q));

endmodule

// File: rtl/serreg_tx.sv
module serreg_tx #(
    parameter int RES_W = 16
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              load,
    input  logic [RES_W-1:0]  load_data,
    input  logic              active,
    output logic              sdo,
    output logic              sdo_oe
);
    logic [RES_W-1:0] tx_sr;

    always_ff @(posedge sclk) begin
        if (rst) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_data;
        end else if (active) begin
            tx_sr <= {tx_sr[RES_W-2:0], 1'b0};
        end
    end

    // launch on the falling edge
    always_ff @(negedge sclk) begin
        if (rst) begin
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else begin
            sdo    <= active & tx_sr[RES_W-1];
            sdo_oe <= active;
        end
    end

endmodule

// File: rtl/serreg_ctrl.sv
module serreg_ctrl
    import serreg_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int RES_W   = 16,
    parameter int RUN_LEN = 32
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              sdi,
    input  logic [RES_W-1:0]  result_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [REG_W-1:0]  setup_q,
    output logic [REG_W-1:0]  test_q,
    output logic              test_mode,
    output logic              ctrl_stb,
    output logic              setup_stb,
    output logic              test_stb,
    output logic              result_stb
);
    localparam int PAD_W = RES_W - REG_W;

    serreg_state_e     state;
    logic [REG_W-1:0]  rx_word;
    logic [1:0]        tgt_sel;
    logic              wr_commit;
    logic              rd_load;
    logic              tx_active;
    logic              resync_hit;
    logic [RES_W-1:0]  load_data;

    serreg_resync #(.RUN_LEN(RUN_LEN)) u_resync (
        .sclk (sclk),
        .rst  (rst),
        .sdi  (sdi),
        .hit  (resync_hit)
    );

    serreg_fsm #(.REG_W(REG_W), .RES_W(RES_W)) u_fsm (
        .sclk       (sclk),
        .rst        (rst),
        .sdi        (sdi),
        .resync_hit (resync_hit),
        .state      (state),
        .rx_word    (rx_word),
        .tgt_sel    (tgt_sel),
        .wr_commit  (wr_commit),
        .rd_load    (rd_load),
        .tx_active  (tx_active)
    );

    serreg_regs #(.REG_W(REG_W)) u_regs (
        .sclk       (sclk),
        .rst        (rst),
        .wr_commit  (wr_commit),
        .rd_load    (rd_load),
        .tgt_sel    (tgt_sel),
        .wdata      (rx_word),
        .ctrl_q     (ctrl_q),
        .setup_q    (setup_q),
        .test_q     (test_q),
        .test_mode  (test_mode),
        .ctrl_stb   (ctrl_stb),
        .setup_stb  (setup_stb),
        .test_stb   (test_stb),
        .result_stb (result_stb)
    );

    // read source, left aligned
    always_comb begin
        unique case (tgt_sel)
            SEL_CTRL:  load_data = {ctrl_q,  {PAD_W{1'b0}}};
            SEL_SETUP: load_data = {setup_q, {PAD_W{1'b0}}};
            SEL_TEST:  load_data = {test_q,  {PAD_W{1'b0}}};
            default:   load_data = result_in;
        endcase
    end

    serreg_tx #(.RES_W(RES_W)) u_tx (
        .sclk      (sclk),
        .rst       (rst),
        .load      (rd_load),
        .load_data (load_data),
        .active    (tx_active),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    p_quiet_out_r10: assert property (@(posedge sclk) disable iff (rst)
        (!tx_active) |-> (!sdo && !sdo_oe));

    p_resync_r8: assert property (@(posedge sclk) disable iff (rst)
        resync_hit |=> (state == ST_COMM));

    p_discard_r7: assert property (@(posedge sclk) disable iff (rst)
        (state == ST_DISC16) |=> ($stable(ctrl_q) && $stable(setup_q) && $stable(test_q)));

endmodule

// File: tb/sim_serreg_ctrl.sv
`timescale 1ns/1ps
module sim_serreg_ctrl;
    logic        sclk = 1'b0;
    logic        rst = 1'b1;
    logic        sdi = 1'b0;
    logic [15:0] result_in = 16'h0000;
    logic        sdo, sdo_oe, test_mode;
    logic [7:0]  ctrl_q, setup_q, test_q;
    logic        ctrl_stb, setup_stb, test_stb, result_stb;

    always #2.5 sclk = ~sclk;   // 200 MHz

    serreg_ctrl u0 (
        .sclk(sclk), .rst(rst), .sdi(sdi), .result_in(result_in),
        .sdo(sdo), .sdo_oe(sdo_oe), .ctrl_q(ctrl_q), .setup_q(setup_q),
        .test_q(test_q), .test_mode(test_mode), .ctrl_stb(ctrl_stb),
        .setup_stb(setup_stb), .test_stb(test_stb), .result_stb(result_stb)
    );

    int    n_cmp = 0;
    int    n_mis = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural model: 0 command, 1 write, 2 read, 4 discard
    int         m_mode, m_cnt, m_ones, m_len, m_txpos;
    logic [7:0] m_acc, m_ctrl, m_setup, m_test;
    logic [1:0] m_sel;
    logic [15:0] m_tx;
    logic [3:0] m_stb;

    task automatic chk(string t, string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    task automatic model_edge(logic b);
        m_stb = 4'b0000;
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_ones = 0; m_acc = 8'h00;
            m_ctrl = 8'h00; m_setup = 8'h00; m_test = 8'h00; m_txpos = 0;
            return;
        end
        m_ones = b ? m_ones + 1 : 0;
        if (m_ones == 32) begin
            m_ones = 0; m_mode = 0; m_cnt = 0;
            return;
        end
        m_acc = {m_acc[6:0], b};
        m_cnt++;
        case (m_mode)
            0: if (m_cnt == 8) begin
                m_cnt = 0;
                if (!m_acc[7]) begin
                    m_sel = m_acc[5:4];
                    if (m_acc[3]) begin
                        m_txpos = 0; m_mode = 2;
                        if (m_sel == 2'b11) begin
                            m_tx = result_in; m_len = 16; m_stb[3] = 1'b1;
                        end else begin
                            m_len = 8;
                            m_tx = {(m_sel == 2'b00) ? m_ctrl : (m_sel == 2'b01) ? m_setup : m_test, 8'h00};
                        end
                    end else begin
                        m_mode = (m_sel == 2'b11) ? 4 : 1;
                    end
                end
            end
            1: if (m_cnt == 8) begin
                m_cnt = 0; m_mode = 0;
                case (m_sel)
                    2'b00: begin m_ctrl = m_acc;  m_stb[0] = 1'b1; end
                    2'b01: begin m_setup = m_acc; m_stb[1] = 1'b1; end
                    default: begin m_test = m_acc; m_stb[2] = 1'b1; end
                endcase
            end
            2: begin
                m_txpos++;
                if (m_cnt == m_len) begin m_cnt = 0; m_mode = 0; end
            end
            default: if (m_cnt == 16) begin m_cnt = 0; m_mode = 0; end
        endcase
    endtask

    task automatic step(logic b);
        logic       e_sdo;
        logic [3:0] act_stb;
        sdi = b;
        @(posedge sclk);
        model_edge(b);
        #1;
        act_stb = {result_stb, test_stb, setup_stb, ctrl_stb};
        chk(tag, "ctrl_q", {8'h00, ctrl_q}, {8'h00, m_ctrl});
        chk(tag, "setup_q", {8'h00, setup_q}, {8'h00, m_setup});
        chk(tag, "test_q", {8'h00, test_q}, {8'h00, m_test});
        chk("R9", "test_mode", {15'h0, test_mode}, {15'h0, (m_test != 8'h00)});
        chk(tag, "strobes", {12'h0, act_stb}, {12'h0, m_stb});
        chk("R10", "strobe count", 16'($countones(act_stb)), 16'($countones(m_stb)));
        @(negedge sclk);
        #1;
        e_sdo = (m_mode == 2) ? m_tx[15 - m_txpos] : 1'b0;
        chk((m_mode == 2) ? tag : "R10", "sdo", {15'h0, sdo}, {15'h0, e_sdo});
        chk((m_mode == 2) ? tag : "R10", "sdo_oe", {15'h0, sdo_oe}, {15'h0, (m_mode == 2)});
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) step(v[i]);
    endtask

    task automatic send_word(logic [15:0] v);
        for (int i = 15; i >= 0; i--) step(v[i]);
    endtask

    task automatic send_ones(int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic hw_reset();
        rst = 1'b1;
        step(1'b0);
        step(1'b0);
        rst = 1'b0;
    endtask

    initial begin
        #1;
        tag = "R1";
        hw_reset();
        chk("R1", "ctrl after reset", {8'h00, ctrl_q}, 16'h0000);
        chk("R1", "sdo after reset", {15'h0, sdo}, 16'h0000);

        tag = "R4";
        send_byte(8'h00); send_byte(8'hA5);
        send_byte(8'h10); send_byte(8'h3C);
        tag = "R3";
        send_byte(8'h47); send_byte(8'h96);   // reserved bits set, write ctrl
        tag = "R5";
        send_byte(8'h08); send_byte(8'h00);
        send_byte(8'h18); send_byte(8'h00);

        tag = "R6";
        result_in = 16'hBEEF;
        send_byte(8'h38);
        for (int i = 0; i < 16; i++) begin
            if (i == 5) result_in = 16'h1234;
            step(1'b0);
        end
        // new result applied in the cycle that completes the command
        for (int i = 7; i >= 1; i--) step(8'h38 >> i);
        result_in = 16'h0F0F;
        step(1'b0);
        send_word(16'h0000);

        tag = "R7";
        send_byte(8'h30); send_word(16'hFFFF);
        send_byte(8'h00); send_byte(8'h11);
        send_byte(8'h37); send_word(16'h5A5A);
        send_byte(8'h10); send_byte(8'h22);

        tag = "R2";
        send_byte(8'h80);
        send_byte(8'h00); send_byte(8'h77);
        send_byte(8'hC8);
        send_byte(8'h08); send_byte(8'h00);

        tag = "R9";
        send_byte(8'h20); send_byte(8'h04);
        send_byte(8'h28); send_byte(8'h00);
        send_ones(32);
        send_byte(8'h20); send_byte(8'h00);
        send_byte(8'h20); send_byte(8'h01);
        hw_reset();
        chk("R9", "test flag after reset", {15'h0, test_mode}, 16'h0000);

        tag = "R8";
        send_ones(32);                        // 32nd one ends a byte
        send_byte(8'h10); send_byte(8'h99);
        for (int i = 0; i < 5; i++) step(1'b0);
        send_ones(40);
        send_byte(8'h10); send_byte(8'h42);
        send_ones(31); step(1'b0);
        send_byte(8'h00); send_byte(8'h66);
        send_byte(8'h38); send_ones(10);
        send_ones(22);
        send_byte(8'h00); send_byte(8'hC3);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            n_cmp++;
            n_mis++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

endmodule